// File: doc/BRIEF.md
# Resource Stream Reader

This block hands a card's resource description to a host one byte at a time. The description sits in a small internal table. The host first reads a status index to learn whether a byte is waiting, then reads a data index to take that byte. Each accepted data read moves an internal byte pointer forward by one. A wake command that the surrounding card logic has accepted moves the pointer back to the first byte.

While bytes stream out, the block decodes item headers on the fly.

- **Small item:** bit 7 of the header is clear. Bits [6:3] give the item name and bits [2:0] give the body length.
- **Large item:** bit 7 of the header is set. Bits [6:0] give the name. Two length bytes follow, least significant first, and then the body.

The block reports the name of the current item and whether it is large. It also raises a flag once the end item (small name 0xF) has been seen. When the end item's own body, its checksum byte, has been handed out, the ready flag stays low until the next wake.

Top module: `rsrc_stream_reader`

## Requirements
- R1: A host read of index 0x04 while the ready flag is high returns, on the next cycle, the table byte at the pointer, and the pointer advances by one.
- R2: A host read of index 0x05 returns the ready flag in bit 0, with bits [7:1] zero.
- R3: The ready flag is low in the cycle after each accepted data read. It is high again one cycle later while the item list is not finished.
- R4: A data read made while the ready flag is low returns 0x00 and leaves the pointer unchanged.
- R5: A wake pulse clears the ready flag for one cycle, returns the pointer to byte 0 and clears the item name, large flag and end flag. A data read in the same cycle as a wake returns 0x00 and is not accepted.
- R6: A header byte with bit 7 = 0 sets the item name to bits [6:3] and clears the large flag. The bits [2:0] body bytes that follow are not treated as headers.
- R7: A header byte with bit 7 = 1 sets the item name to bits [6:0] and sets the large flag. The next two bytes are the body length, low byte first, and that many body bytes follow before the next header.
- R8: A small header with name 0xF sets the end flag. After its body bytes (the checksum) have been read, the ready flag stays low and status reads return 0x00.
- R9: Host reads of any index other than 0x04 and 0x05 return 0x00 and do not move the pointer.
- R10: In reset the ready flag, read data, item name, large flag and end flag are all zero. The ready flag rises one cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_idx | input | IDX_W | Register index of the host read |
| host_wake | input | 1 | Pulse: a wake command was accepted for this card |
| host_rdata | output | 8 | Registered read data, valid the cycle after the strobe |
| res_ready | output | 1 | Next resource byte may be read |
| item_name | output | 7 | Name of the item whose header was read last |
| item_large | output | 1 | Current item is a large item |
| list_end | output | 1 | End item header has been read |

## Verification
On every cycle, assertions check the following:
- the ready gap after an accepted read;
- the rewind on wake;
- that the pointer steps by one per accepted read and holds otherwise;
- the status read encoding;
- that ready stays low once the list is finished;
- that the end flag only ever accompanies small name 0xF.

Only the bench's scenarios can show three further things: that each returned byte matches the table; that length fields of both header formats make the tracker skip the right number of body bytes; and that a wake arriving mid-item restarts decoding from a clean header.

// File: rtl/rsrc_pkg.sv
package rsrc_pkg;

  localparam int unsigned RSRC_IDX_DATA   = 32'h04;
  localparam int unsigned RSRC_IDX_STATUS = 32'h05;
  localparam logic [3:0]  RSRC_END_NAME   = 4'hF;

  typedef enum logic [2:0] {
    PS_HDR,
    PS_LEN_LO,
    PS_LEN_HI,
    PS_BODY,
    PS_DONE
  } parse_state_t;

  // Default resource table: small(1,len2), large(2,len3), small(8,len7),
  // small(7,len0), end(len1 checksum). Unlisted bytes read as zero.
  function automatic logic [7:0] rsrc_default_byte(input int unsigned i);
    case (i)
      0:  return 8'h0A;
      1:  return 8'h10;
      2:  return 8'h01;
      3:  return 8'h82;
      4:  return 8'h03;
      5:  return 8'h00;
      6:  return 8'h41;
      7:  return 8'h42;
      8:  return 8'h43;
      9:  return 8'h47;
      10: return 8'h01;
      11: return 8'h20;
      12: return 8'h02;
      13: return 8'h20;
      14: return 8'h02;
      15: return 8'h08;
      16: return 8'h08;
      17: return 8'h38;
      18: return 8'h79;
      19: return 8'h5A;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rsrc_rom.sv
module rsrc_rom #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  import rsrc_pkg::*;

  logic [7:0] mem [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
      assign mem[g] = rsrc_default_byte(g);
    end
  endgenerate

  assign q = mem[addr];
endmodule

// File: rtl/rsrc_item_tracker.sv
module rsrc_item_tracker (
  input  logic       clk,
  input  logic       rst,
  input  logic       wake,
  input  logic       adv,
  input  logic [7:0] byte_in,
  output logic [6:0] item_name,
  output logic       item_large,
  output logic       list_end,
  output logic       done
);
  import rsrc_pkg::*;

  parse_state_t state;
  logic [15:0]  remain;

  always_ff @(posedge clk) begin
    if (rst || wake) begin
      state      <= PS_HDR;
      remain     <= '0;
      item_name  <= '0;
      item_large <= 1'b0;
      list_end   <= 1'b0;
    end else if (adv) begin
      unique case (state)
        PS_HDR: begin
          if (byte_in[7]) begin
            item_large <= 1'b1;
            item_name  <= byte_in[6:0];
            state      <= PS_LEN_LO;
          end else begin
            item_large <= 1'b0;
            item_name  <= {3'b000, byte_in[6:3]};
            remain     <= {13'd0, byte_in[2:0]};
            if (byte_in[6:3] == RSRC_END_NAME) list_end <= 1'b1;
            if (byte_in[2:0] != 3'd0)
              state <= PS_BODY;
            else if (byte_in[6:3] == RSRC_END_NAME)
              state <= PS_DONE;
          end
        end
        PS_LEN_LO: begin
          remain <= {8'h00, byte_in};
          state  <= PS_LEN_HI;
        end
        PS_LEN_HI: begin
          remain <= {byte_in, remain[7:0]};
          state  <= ({byte_in, remain[7:0]} == 16'd0) ? PS_HDR : PS_BODY;
        end
        PS_BODY: begin
          remain <= remain - 16'd1;
          if (remain == 16'd1) state <= list_end ? PS_DONE : PS_HDR;
        end
        default: ;
      endcase
    end
  end

  assign done = (state == PS_DONE);

  // R8: end flag only ever accompanies the small end item name
  assert_end_tag_R8: assert property (@(posedge clk) disable iff (rst)
    list_end |-> (item_name == 7'h0F && !item_large));

  // R7: length bytes are only collected for a large item
  assert_large_len_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PS_LEN_LO || state == PS_LEN_HI) |-> item_large);

  // R8: finished state is reached only through the end item
  assert_done_end_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> list_end);
endmodule

// File: rtl/rsrc_stream_reader.sv
module rsrc_stream_reader #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_rd,
  input  logic [IDX_W-1:0] host_idx,
  input  logic             host_wake,
  output logic [7:0]       host_rdata,
  output logic             res_ready,
  output logic [6:0]       item_name,
  output logic             item_large,
  output logic             list_end
);
  import rsrc_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0]    LAST    = AW'(DEPTH - 1);
  localparam logic [IDX_W-1:0] IDX_DAT = IDX_W'(RSRC_IDX_DATA);
  localparam logic [IDX_W-1:0] IDX_STS = IDX_W'(RSRC_IDX_STATUS);

  logic [AW-1:0] ptr;
  logic          ready_q;
  logic          exhausted;
  logic          parse_done;
  logic          accept;
  logic [7:0]    rom_q;

  assign accept = host_rd && (host_idx == IDX_DAT) && ready_q && !host_wake;

  rsrc_rom #(.DEPTH(DEPTH), .AW(AW)) u_rom (
    .addr (ptr),
    .q    (rom_q)
  );

  rsrc_item_tracker u_trk (
    .clk        (clk),
    .rst        (rst),
    .wake       (host_wake),
    .adv        (accept),
    .byte_in    (rom_q),
    .item_name  (item_name),
    .item_large (item_large),
    .list_end   (list_end),
    .done       (parse_done)
  );

  always_ff @(posedge clk) begin
    if (rst || host_wake) begin
      ptr       <= '0;
      exhausted <= 1'b0;
    end else if (accept) begin
      if (ptr == LAST) exhausted <= 1'b1;
      else             ptr       <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || host_wake || accept) ready_q <= 1'b0;
    else                            ready_q <= !(parse_done || exhausted);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= 8'h00;
    end else if (host_rd) begin
      if (host_idx == IDX_DAT)      host_rdata <= accept ? rom_q : 8'h00;
      else if (host_idx == IDX_STS) host_rdata <= {7'b0, ready_q};
      else                          host_rdata <= 8'h00;
    end
  end

  assign res_ready = ready_q;

  // R3: ready drops right after an accepted data read
  assert_ready_gap_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !res_ready);

  // R1: pointer steps by one per accepted read
  assert_advance_R1: assert property (@(posedge clk) disable iff (rst)
    (accept && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

  // R4: without an accepted read or wake the pointer holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!accept && !host_wake) |=> $stable(ptr));

  // R5: wake rewinds and drops ready for a cycle
  assert_wake_rewind_R5: assert property (@(posedge clk) disable iff (rst)
    host_wake |=> (ptr == '0 && !res_ready && !list_end));

  // R2: status read reports the ready flag of the read cycle
  assert_status_R2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_idx == IDX_STS) |=> host_rdata == {7'b0, $past(res_ready)});

  // R8: a finished list never shows ready
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (parse_done || exhausted) |-> !res_ready);
endmodule

// File: tb/tb_rsrc_stream_reader.sv
module tb_rsrc_stream_reader;
  localparam int NB = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_rd = 1'b0;
  logic [7:0] host_idx = 8'h00;
  logic       host_wake = 1'b0;
  logic [7:0] host_rdata;
  logic       res_ready;
  logic [6:0] item_name;
  logic       item_large;
  logic       list_end;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] tbl [NB] = '{8'h0A, 8'h10, 8'h01, 8'h82, 8'h03, 8'h00, 8'h41,
                           8'h42, 8'h43, 8'h47, 8'h01, 8'h20, 8'h02, 8'h20,
                           8'h02, 8'h08, 8'h08, 8'h38, 8'h79, 8'h5A};

  // expected item tracking
  int m_st, m_cnt, m_name, m_large, m_end;

  rsrc_stream_reader dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_idx(host_idx),
    .host_wake(host_wake), .host_rdata(host_rdata), .res_ready(res_ready),
    .item_name(item_name), .item_large(item_large), .list_end(list_end)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic read_cycle(input logic [7:0] idx);
    host_rd = 1'b1;
    host_idx = idx;
    step();
    host_rd = 1'b0;
  endtask

  task automatic wake_pulse();
    host_wake = 1'b1;
    step();
    host_wake = 1'b0;
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_name = 0; m_large = 0; m_end = 0;
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_st)
      0: if (b[7]) begin
           m_large = 1; m_name = int'(b[6:0]); m_st = 1;
         end else begin
           m_large = 0; m_name = int'(b[6:3]); m_cnt = int'(b[2:0]);
           if (b[6:3] == 4'hF) m_end = 1;
           if (m_cnt != 0) m_st = 3;
           else if (m_end != 0) m_st = 4;
         end
      1: begin m_cnt = int'(b); m_st = 2; end
      2: begin
           m_cnt = m_cnt + 256 * int'(b);
           m_st = (m_cnt == 0) ? 0 : 3;
         end
      3: begin
           m_cnt--;
           if (m_cnt == 0) m_st = (m_end != 0) ? 4 : 0;
         end
      default: ;
    endcase
  endtask

  task automatic sweep(input int gap, input bit reject_probe);
    model_reset();
    for (int k = 0; k < NB; k++) begin
      step();
      repeat (gap) step();
      chk(res_ready == 1'b1, "R3", "ready back before byte", int'(res_ready), 1);
      read_cycle(8'h04);
      chk(host_rdata == tbl[k], "R1", $sformatf("byte %0d", k),
          int'(host_rdata), int'(tbl[k]));
      chk(res_ready == 1'b0, "R3", "ready gap after read", int'(res_ready), 0);
      model_byte(tbl[k]);
      chk(int'(item_name) == m_name,
          (m_large != 0) ? "R7" : "R6", $sformatf("item name after byte %0d", k),
          int'(item_name), m_name);
      chk(int'(item_large) == m_large,
          (m_large != 0) ? "R7" : "R6", $sformatf("large flag after byte %0d", k),
          int'(item_large), m_large);
      chk(int'(list_end) == m_end, "R8", $sformatf("end flag after byte %0d", k),
          int'(list_end), m_end);
      if (reject_probe && k == 2) begin
        read_cycle(8'h04);
        chk(host_rdata == 8'h00, "R4", "read while not ready", int'(host_rdata), 0);
      end
    end
  endtask

  initial begin
    repeat (3) step();
    chk(res_ready == 1'b0, "R10", "ready in reset", int'(res_ready), 0);
    chk(host_rdata == 8'h00, "R10", "rdata in reset", int'(host_rdata), 0);
    chk(item_name == 7'd0 && !item_large && !list_end, "R10", "flags in reset",
        int'({item_name, item_large, list_end}), 0);
    rst = 1'b0;
    step();
    chk(res_ready == 1'b1, "R10", "ready after reset", int'(res_ready), 1);

    read_cycle(8'h05);
    chk(host_rdata == 8'h01, "R2", "status when ready", int'(host_rdata), 1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] idx;
      idx = (i == 0) ? 8'h00 : (i == 1) ? 8'h06 : (i == 2) ? 8'h07 : 8'h31;
      read_cycle(idx);
      chk(host_rdata == 8'h00, "R9", $sformatf("other index 0x%0h", idx),
          int'(host_rdata), 0);
    end
    chk(res_ready == 1'b1, "R9", "ready kept after other reads", int'(res_ready), 1);

    sweep(0, 1'b1);
    repeat (4) begin
      step();
      chk(res_ready == 1'b0, "R8", "ready stays low after end", int'(res_ready), 0);
    end
    read_cycle(8'h05);
    chk(host_rdata == 8'h00, "R8", "status after end", int'(host_rdata), 0);
    read_cycle(8'h04);
    chk(host_rdata == 8'h00, "R4", "data read after end", int'(host_rdata), 0);

    wake_pulse();
    chk(res_ready == 1'b0, "R5", "ready low after wake", int'(res_ready), 0);
    chk(item_name == 7'd0 && !item_large && !list_end, "R5", "flags cleared by wake",
        int'({item_name, item_large, list_end}), 0);
    step();
    chk(res_ready == 1'b1, "R5", "ready after wake", int'(res_ready), 1);

    for (int k = 0; k < 9; k++) begin
      read_cycle(8'h04);
      chk(host_rdata == tbl[k], "R1", $sformatf("partial byte %0d", k),
          int'(host_rdata), int'(tbl[k]));
      step();
    end
    chk(item_large == 1'b1, "R7", "inside large item", int'(item_large), 1);
    host_wake = 1'b1;
    read_cycle(8'h04);
    host_wake = 1'b0;
    chk(host_rdata == 8'h00, "R5", "read blocked by wake", int'(host_rdata), 0);
    chk(item_name == 7'd0 && !item_large, "R5", "mid-item wake clears item",
        int'({item_name, item_large}), 0);
    step();
    read_cycle(8'h04);
    chk(host_rdata == tbl[0], "R5", "first byte after wake", int'(host_rdata),
        int'(tbl[0]));

    wake_pulse();
    sweep(2, 1'b0);
    step();
    chk(res_ready == 1'b0, "R8", "ready low after second pass", int'(res_ready), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule